// File: doc/BRIEF.md
# Transmit Channel Teardown and Suspend Controller

This block controls four transmit DMA channels. Software configures each channel through a plain 32-bit register bus. A channel register holds four things: an enable bit, a teardown-request bit, and a queue-manager/queue-number pair that says where the teardown notice goes. While a channel is enabled and has pending work, it launches transactions one at a time. Each transaction is a one-cycle start pulse answered later by a done pulse.

A teardown request never aborts work that is already running. The channel first lets its current transaction finish. It then offers one notification on a shared valid/ready output that carries the channel index and the stored queue pair. Once that notification is accepted, the hardware clears the enable bit and leaves the request bit set for software to clear.

A separate emulation control register gates the effect of a suspend input. It has a free-run bit and a soft bit. With free-run low and soft high, an asserted suspend holds a channel idle once its current transaction has finished. Work resumes as soon as suspend drops, with no software action.

Back-pressure on the notification output works as follows:
- While `td_valid` is high and `td_ready` is low, the channel index and the queue fields stay unchanged.
- A notification counts as delivered only in a cycle where both `td_valid` and `td_ready` are high.

Top module: `txch_ctrl`

## Requirements
- R1: After reset, every register reads 0, no start pulse is issued and `td_valid` is low.
- R2: Channel n sits at word address n (0 to 3). On a write, bit 31 is the enable, bit 30 is the teardown request, bits 13:12 are the queue manager and bits 11:0 are the queue number. A read returns only bits 31:30; all other bits read 0.
- R3: The emulation register sits at word address 4. Bit 0 is free-run and bit 1 is soft. Bits 31:2 read 0.
- R4: A start pulse is issued only when the channel is enabled, has no teardown request, is not halted and has pending work. After a start, no further start is issued for that channel until its done pulse.
- R5: A teardown request on an enabled idle channel produces exactly one notification carrying the channel index and the stored queue pair. After acceptance, the register reads enable 0 and teardown 1. A teardown request on a disabled channel produces no notification.
- R6: A teardown request on a busy channel produces no notification before that channel's done pulse.
- R7: While `td_valid` is high and `td_ready` is low, the payload is held. When several channels begin waiting in the same cycle, the lowest channel index is delivered first.
- R8: With free-run 0 and soft 1, an asserted suspend lets the in-flight transaction complete but prevents any new start.
- R9: Suspend has no effect when free-run is 1, whatever soft holds. It also has no effect when both bits are 0.
- R10: A halted channel with pending work issues its start in the first cycle in which suspend reads low.
- R11: If a software write to a channel register lands in the same cycle as acceptance of that channel's notification, the enable ends up 0 and the teardown bit takes the written value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 3 | Register word address |
| bus_wen | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data (combinational from address) |
| emu_susp | input | 1 | Emulation suspend request |
| xfer_pend | input | 4 | Per-channel pending work |
| xfer_start | output | 4 | Per-channel one-cycle transaction start |
| xfer_done | input | 4 | Per-channel transaction completion pulse |
| td_valid | output | 1 | Teardown notification valid |
| td_ready | input | 1 | Teardown notification accepted |
| td_chan | output | 2 | Channel index of the notification |
| td_qmgr | output | 2 | Destination queue manager |
| td_qnum | output | 12 | Destination queue number |

## Verification
Two actions can land on the same enable flip-flop in one cycle: the hardware clear that follows notification acceptance, and a software write to that channel register. The bench holds `td_ready` low so that a notification waits. It then raises `td_ready` in the very cycle that a write of enable 1, teardown 0 arrives. The expected result is a single delivered notification carrying the old queue pair, followed by a register read of all zeros. A second case makes two busy channels reach their done pulse together, and the bench judges the delivery order against the lowest-index rule.

// File: rtl/txch_pkg.sv
package txch_pkg;
  typedef enum logic [1:0] {
    CH_IDLE   = 2'd0,
    CH_BUSY   = 2'd1,
    CH_TDWAIT = 2'd2
  } ch_state_e;

  localparam int EN_BIT = 31;
  localparam int TD_BIT = 30;
  localparam int FREE_BIT = 0;
  localparam int SOFT_BIT = 1;
endpackage

// File: rtl/txch_fsm.sv
module txch_fsm
  import txch_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic td,
  input  logic halt,
  input  logic pend,
  input  logic done,
  input  logic grant,
  output logic start,
  output logic push_req,
  output logic clr_en
);
  ch_state_e state_q, state_d;

  always_comb begin
    state_d  = state_q;
    start    = 1'b0;
    push_req = 1'b0;
    clr_en   = 1'b0;
    case (state_q)
      CH_IDLE: begin
        if (en && td) begin
          state_d = CH_TDWAIT;
        end else if (en && !halt && pend) begin
          start   = 1'b1;
          state_d = CH_BUSY;
        end
      end
      CH_BUSY: begin
        if (done) state_d = (en && td) ? CH_TDWAIT : CH_IDLE;
      end
      CH_TDWAIT: begin
        push_req = 1'b1;
        if (grant) begin
          clr_en  = 1'b1;
          state_d = CH_IDLE;
        end
      end
      default: state_d = CH_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state_q <= CH_IDLE;
    else        state_q <= state_d;
  end

  // R4: a transaction lasts at least one cycle, so starts never come back to back
  p_single_start_r4: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> !start);
endmodule

// File: rtl/td_push_arb.sv
module td_push_arb #(
  parameter int NUM_CH = 4,
  localparam int CH_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_CH-1:0] req,
  input  logic              ready,
  output logic              valid,
  output logic [CH_W-1:0]   sel,
  output logic [NUM_CH-1:0] grant
);
  logic            held_q;
  logic [CH_W-1:0] held_idx_q;
  logic [CH_W-1:0] pick;

  always_comb begin
    pick = '0;
    for (int i = NUM_CH - 1; i >= 0; i--) begin
      if (req[i]) pick = CH_W'(i);
    end
    if (held_q) pick = held_idx_q;
  end

  assign valid = held_q | (|req);
  assign sel   = pick;

  always_comb begin
    grant = '0;
    if (valid && ready) grant[pick] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      held_q     <= 1'b0;
      held_idx_q <= '0;
    end else begin
      held_q     <= valid && !ready;
      held_idx_q <= pick;
    end
  end
endmodule

// File: rtl/txch_ctrl.sv
module txch_ctrl
  import txch_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int QM_W   = 2,
  parameter int QN_W   = 12,
  parameter int ADDR_W = 3,
  localparam int CH_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wen,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic              emu_susp,
  input  logic [NUM_CH-1:0] xfer_pend,
  output logic [NUM_CH-1:0] xfer_start,
  input  logic [NUM_CH-1:0] xfer_done,
  output logic              td_valid,
  input  logic              td_ready,
  output logic [CH_W-1:0]   td_chan,
  output logic [QM_W-1:0]   td_qmgr,
  output logic [QN_W-1:0]   td_qnum
);
  localparam int EMU_ADDR = NUM_CH;
  localparam int QM_LO    = QN_W;
  localparam int QM_HI    = QN_W + QM_W - 1;

  logic [NUM_CH-1:0] cfg_en, cfg_td;
  logic [QM_W-1:0]   cfg_qm [NUM_CH];
  logic [QN_W-1:0]   cfg_qn [NUM_CH];
  logic              emu_free, emu_soft;
  logic              halt;
  logic [NUM_CH-1:0] push_req, grant, clr_en;
  logic [CH_W-1:0]   sel;
  logic              unused_wbits;

  assign unused_wbits = ^{bus_wdata[29:QM_HI+1]};
  assign halt = emu_susp && !emu_free && emu_soft;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg_en   <= '0;
      cfg_td   <= '0;
      emu_free <= 1'b0;
      emu_soft <= 1'b0;
      for (int i = 0; i < NUM_CH; i++) begin
        cfg_qm[i] <= '0;
        cfg_qn[i] <= '0;
      end
    end else begin
      for (int i = 0; i < NUM_CH; i++) begin
        if (bus_wen && bus_addr == ADDR_W'(i)) begin
          cfg_en[i] <= bus_wdata[EN_BIT];
          cfg_td[i] <= bus_wdata[TD_BIT];
          cfg_qm[i] <= bus_wdata[QM_HI:QM_LO];
          cfg_qn[i] <= bus_wdata[QN_W-1:0];
        end
        if (clr_en[i]) cfg_en[i] <= 1'b0;
      end
      if (bus_wen && bus_addr == ADDR_W'(EMU_ADDR)) begin
        emu_free <= bus_wdata[FREE_BIT];
        emu_soft <= bus_wdata[SOFT_BIT];
      end
    end
  end

  always_comb begin
    bus_rdata = '0;
    for (int i = 0; i < NUM_CH; i++) begin
      if (bus_addr == ADDR_W'(i)) begin
        bus_rdata[EN_BIT] = cfg_en[i];
        bus_rdata[TD_BIT] = cfg_td[i];
      end
    end
    if (bus_addr == ADDR_W'(EMU_ADDR)) begin
      bus_rdata[FREE_BIT] = emu_free;
      bus_rdata[SOFT_BIT] = emu_soft;
    end
  end

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    txch_fsm i_fsm (
      .clk      (clk),
      .rst_n    (rst_n),
      .en       (cfg_en[g]),
      .td       (cfg_td[g]),
      .halt     (halt),
      .pend     (xfer_pend[g]),
      .done     (xfer_done[g]),
      .grant    (grant[g]),
      .start    (xfer_start[g]),
      .push_req (push_req[g]),
      .clr_en   (clr_en[g])
    );

    // R5: acceptance of the notice leaves the channel disabled
    p_en_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
      grant[g] |=> !cfg_en[g]);
  end

  td_push_arb #(.NUM_CH(NUM_CH)) i_arb (
    .clk   (clk),
    .rst_n (rst_n),
    .req   (push_req),
    .ready (td_ready),
    .valid (td_valid),
    .sel   (sel),
    .grant (grant)
  );

  assign td_chan = sel;
  assign td_qmgr = cfg_qm[sel];
  assign td_qnum = cfg_qn[sel];

  // R7: a stalled notice keeps its payload
  p_push_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (td_valid && !td_ready) |=> (td_valid && $stable(td_chan) && $stable(td_qmgr) && $stable(td_qnum)));

  // R8: no new transaction while halted
  p_halt_no_start_r8: assert property (@(posedge clk) disable iff (!rst_n)
    halt |-> (xfer_start == '0));

  // R1: nothing issued in the first cycle after reset
  p_reset_quiet_r1: assert property (@(posedge clk)
    !rst_n |=> (!td_valid && xfer_start == '0));
endmodule

// File: tb/test_txch_ctrl.sv
module test_txch_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  bus_addr = '0;
  logic        bus_wen = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        emu_susp = 1'b0;
  logic [3:0]  xfer_pend = '0;
  logic [3:0]  xfer_start;
  logic [3:0]  xfer_done = '0;
  logic        td_valid;
  logic        td_ready = 1'b1;
  logic [1:0]  td_chan;
  logic [1:0]  td_qmgr;
  logic [11:0] td_qnum;

  int checks = 0;
  int errors = 0;
  int pops = 0;
  int start_cnt [4] = '{0, 0, 0, 0};
  bit finished = 1'b0;
  logic [15:0] exp_q [$];

  always #10 clk = ~clk;

  txch_ctrl i_txch_ctrl (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wen(bus_wen),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .emu_susp(emu_susp),
    .xfer_pend(xfer_pend), .xfer_start(xfer_start), .xfer_done(xfer_done),
    .td_valid(td_valid), .td_ready(td_ready), .td_chan(td_chan),
    .td_qmgr(td_qmgr), .td_qnum(td_qnum)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    bus_addr = a; bus_wdata = d; bus_wen = 1'b1;
    tick();
    bus_wen = 1'b0;
  endtask

  task automatic rdchk(input logic [2:0] a, input logic [31:0] exp, input string req);
    bus_addr = a;
    #1;
    check(req, bus_rdata, exp);
  endtask

  task automatic pulse_done(input logic [3:0] m);
    xfer_done = m;
    tick();
    xfer_done = '0;
  endtask

  task automatic expect_push(input logic [1:0] ch, input logic [1:0] qm, input logic [11:0] qn);
    exp_q.push_back({ch, qm, qn});
  endtask

  task automatic report();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  // monitor: scoreboard pops and start counting
  always @(negedge clk) begin
    if (rst_n) begin
      for (int i = 0; i < 4; i++) if (xfer_start[i]) start_cnt[i]++;
      if (td_valid && td_ready) begin
        pops++;
        if (exp_q.size() == 0) begin
          check("R5 unexpected notice", {16'h0, td_chan, td_qmgr, td_qnum}, 32'hFFFF_FFFF);
        end else begin
          logic [15:0] e;
          e = exp_q.pop_front();
          check("R5/R7 notice payload", {16'h0, td_chan, td_qmgr, td_qnum}, {16'h0, e});
        end
      end
    end
  end

  initial begin
    #(200000 * 20);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      report();
      $finish;
    end
  end

  initial begin
    repeat (3) tick();
    rst_n = 1'b1;
    tick();

    // R1 reset state
    for (int a = 0; a < 5; a++) rdchk(3'(a), 32'h0, "R1 register reset");
    check("R1 td_valid", {31'h0, td_valid}, 32'h0);

    // R2 layout and read mask
    wr(3'd1, 32'h0000_2ABC);
    rdchk(3'd1, 32'h0, "R2 queue fields read 0");
    wr(3'd1, 32'h8000_2ABC);
    rdchk(3'd1, 32'h8000_0000, "R2 enable bit 31");

    // R3 emulation register
    wr(3'd4, 32'hFFFF_FFFF);
    rdchk(3'd4, 32'h0000_0003, "R3 upper bits read 0");
    wr(3'd4, 32'h0);

    // R4 start gating, one at a time
    xfer_pend = 4'b0011;
    repeat (5) tick();
    check("R4 single start while busy", start_cnt[1], 1);
    check("R4 disabled channel no start", start_cnt[0], 0);
    xfer_pend[0] = 1'b0;
    pulse_done(4'b0010);
    repeat (3) tick();
    check("R4 restart after done", start_cnt[1], 2);

    // R6 teardown on busy channel waits for done
    expect_push(2'd1, 2'd2, 12'hABC);
    wr(3'd1, 32'hC000_2ABC);
    repeat (4) tick();
    check("R6 no notice before done", {31'h0, td_valid}, 32'h0);
    check("R6 no pop before done", pops, 0);
    xfer_pend[1] = 1'b0;
    pulse_done(4'b0010);
    repeat (3) tick();
    check("R6 notice after done", pops, 1);
    rdchk(3'd1, 32'h4000_0000, "R5 enable cleared, teardown kept");
    check("R6 no restart after teardown", start_cnt[1], 2);

    // R5 idle teardown and disabled teardown
    expect_push(2'd2, 2'd1, 12'h123);
    wr(3'd2, 32'hC000_1123);
    repeat (4) tick();
    check("R5 idle teardown notice", pops, 2);
    rdchk(3'd2, 32'h4000_0000, "R5 idle enable cleared");
    wr(3'd3, 32'h4000_0FFF);
    repeat (4) tick();
    check("R5 disabled channel no notice", pops, 2);

    // R7 back-pressure hold
    td_ready = 1'b0;
    expect_push(2'd3, 2'd3, 12'hFFF);
    wr(3'd3, 32'hC000_3FFF);
    expect_push(2'd0, 2'd0, 12'h005);
    wr(3'd0, 32'hC000_0005);
    repeat (3) tick();
    check("R7 valid held", {31'h0, td_valid}, 32'h1);
    check("R7 held channel", {30'h0, td_chan}, 32'd3);
    check("R7 held qnum", {20'h0, td_qnum}, 32'hFFF);
    td_ready = 1'b1;
    repeat (4) tick();
    check("R7 both delivered", pops, 4);

    // R7 lowest index first when both start waiting together
    wr(3'd1, 32'h8000_0011);
    wr(3'd2, 32'h8000_1022);
    xfer_pend = 4'b0110;
    repeat (2) tick();
    check("R4 ch2 started", start_cnt[2], 1);
    expect_push(2'd1, 2'd0, 12'h011);
    expect_push(2'd2, 2'd1, 12'h022);
    wr(3'd2, 32'hC000_1022);
    wr(3'd1, 32'hC000_0011);
    xfer_pend = 4'b0000;
    pulse_done(4'b0110);
    repeat (4) tick();
    check("R7 priority delivery", pops, 6);

    // R8 suspend halts after current transaction
    wr(3'd4, 32'h0000_0002);
    wr(3'd0, 32'h8000_0000);
    xfer_pend[0] = 1'b1;
    repeat (2) tick();
    check("R8 started before suspend", start_cnt[0], 1);
    emu_susp = 1'b1;
    pulse_done(4'b0001);
    repeat (4) tick();
    check("R8 halted while suspended", start_cnt[0], 1);

    // R10 resume in first cycle without suspend
    emu_susp = 1'b0;
    tick();
    check("R10 immediate resume", start_cnt[0], 2);

    // R9 free-run ignores suspend, and both bits 0 ignore it
    wr(3'd4, 32'h0000_0003);
    emu_susp = 1'b1;
    pulse_done(4'b0001);
    repeat (2) tick();
    check("R9 free-run keeps running", start_cnt[0], 3);
    wr(3'd4, 32'h0000_0000);
    pulse_done(4'b0001);
    repeat (2) tick();
    check("R9 soft 0 keeps running", start_cnt[0], 4);
    emu_susp = 1'b0;
    xfer_pend = 4'b0000;
    pulse_done(4'b0001);
    tick();

    // R11 write and hardware clear in the same cycle
    td_ready = 1'b0;
    expect_push(2'd3, 2'd2, 12'h007);
    wr(3'd3, 32'hC000_2007);
    repeat (2) tick();
    check("R11 notice waiting", {31'h0, td_valid}, 32'h1);
    bus_addr = 3'd3; bus_wdata = 32'h8000_1234; bus_wen = 1'b1; td_ready = 1'b1;
    tick();
    bus_wen = 1'b0;
    repeat (2) tick();
    rdchk(3'd3, 32'h0000_0000, "R11 enable cleared, teardown from write");
    check("R11 single notice", pops, 7);
    check("R5 scoreboard drained", exp_q.size(), 0);

    finished = 1'b1;
    report();
    $finish;
  end
endmodule